// File: doc/BRIEF.md
# Sensor Start-up Configuration Sequencer

This block runs a fixed power-up conversation with a camera module on an I2C bus. One start pulse sets it going. It first reads the module's 16-bit status word. It then writes three 16-bit configuration registers, which switch on automatic gain control. Last, it reads the status word again. Both status words are kept in output registers so the host can compare them. At the end the block raises either done or error.

The block does not toggle SCL or SDA itself. It hands byte-level commands (start condition, write byte, read byte, stop condition) to an external bit engine. The handshake is a request that is held until the engine pulses an acknowledge. Every transaction goes to the 7-bit device address 0x2A, on a bus that the bit engine times at 100 kHz. Register addresses and data are 16 bits wide and are sent high byte first. The configuration registers and their values come from a small parameter table.

Top module: `i2c_cfg_sequencer`

## Requirements
- R1: A one-cycle `start` while idle begins the sequence. `busy` is high in the first cycle after the start edge, and `cmd_req` rises one cycle after that. A `start` while busy is ignored: the command stream and the results are unchanged.
- R2: The first transaction reads status register 0x0002. The commands are: START, WRITE 0x54, WRITE 0x00, WRITE 0x02, START, WRITE 0x55, READ with `cmd_rd_nack`=0, READ with `cmd_rd_nack`=1, STOP. Op codes on `cmd_op` are START=0, WRITE=1, READ=2, STOP=3.
- R3: Three write transactions follow, to registers 0x0008, 0x000A and 0x0004 in that order. Their data values by default are 0x0001, 0x0002 and 0x0101. Each transaction is START, WRITE 0x54, WRITE register high byte, WRITE register low byte, WRITE data high byte, WRITE data low byte, STOP.
- R4: A final transaction identical to R2 reads the status again. `done` rises in the cycle after the acknowledge of its STOP.
- R5: The first byte read in a status transaction becomes bits 15:8 and the second becomes bits 7:0. The first read goes to `status_first` and the final read goes to `status_final`.
- R6: A NACK reported with the acknowledge of a WRITE makes the next command a STOP. Once that STOP is acknowledged, `error` rises and `err_step` holds the failing transaction. Transactions are numbered 0 (first status read), 1 to 3 (the writes) and 4 (final status read).
- R7: `rsp_nack` is ignored with the acknowledge of START, READ or STOP. In that case the sequence runs to completion and ends with `done`.
- R8: While `cmd_req` is high and no acknowledge has come, `cmd_req`, `cmd_op` and `cmd_wdata` hold steady. After each acknowledge, `cmd_req` is low for at least one cycle.
- R9: `done` and `error` are never high together and are both low while `busy` is high. Each stays high until the next accepted `start`.
- R10: After reset `busy`, `done`, `error` and `cmd_req` are low and both status outputs read zero. A reset during a run returns the block to this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts the sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed without NACK |
| error | output | 1 | Sequence aborted on a NACK |
| err_step | output | 3 | Transaction index of the abort |
| status_first | output | 16 | Status word from the first read |
| status_final | output | 16 | Status word from the final read |
| cmd_req | output | 1 | Command request to the bit engine |
| cmd_op | output | 2 | Command op: 0 start, 1 write, 2 read, 3 stop |
| cmd_wdata | output | 8 | Byte to write |
| cmd_rd_nack | output | 1 | For READ: master answers NACK (last byte) |
| cmd_ack | input | 1 | One-cycle completion pulse from the bit engine |
| rsp_nack | input | 1 | Slave NACK, valid with cmd_ack |
| rsp_rdata | input | 8 | Read byte, valid with cmd_ack |

## Verification
Every result has a fixed latency, counted in clock edges. `busy` is due one edge after the start edge. The first request is due two edges after it. The command after an acknowledge is due two edges after the acknowledge edge. `done` or `error` is due one edge after the acknowledge of the closing STOP. The bench drives all inputs on falling edges and samples on falling edges at exactly those counts. Its bit-engine model logs each request in the cycle it acknowledges it and checks the hold and gap rules of R8 from one cycle to the next. Whole-run results are read only once `busy` has dropped, and are read again some cycles later to confirm that they hold.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOAD = 2'd1,
    S_WAIT = 2'd2
  } seq_state_e;

  // commands in a status-read and in a register-write transaction
  localparam int RD_OPS = 9;
  localparam int WR_OPS = 7;
  localparam int IDX_W  = 4;

endpackage

// File: rtl/i2c_cfg_cmd_table.sv
module i2c_cfg_cmd_table
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0]         DEV_ADDR   = 7'h2A,
  parameter logic [15:0]        STATUS_REG = 16'h0002,
  parameter int                 N_CFG      = 3,
  parameter logic [N_CFG*16-1:0] CFG_REGS  = {16'h0004, 16'h000A, 16'h0008},
  parameter logic [N_CFG*16-1:0] CFG_DATA  = {16'h0101, 16'h0002, 16'h0001},
  localparam int                N_STEPS    = N_CFG + 2,
  localparam int                STEP_W     = $clog2(N_STEPS)
) (
  input  logic [STEP_W-1:0] step,
  input  logic [IDX_W-1:0]  idx,
  output op_e               op,
  output logic [7:0]        wbyte,
  output logic              rd_nack,
  output logic              last
);

  logic        is_rd;
  logic [15:0] reg_addr;
  logic [15:0] reg_data;
  int unsigned cfg_i;

  always_comb begin
    is_rd = (step == '0) || (step == STEP_W'(N_STEPS - 1));
    cfg_i = is_rd ? 0 : (int'(step) - 1);
    reg_addr = is_rd ? STATUS_REG : CFG_REGS[16*cfg_i +: 16];
    reg_data = is_rd ? 16'h0000   : CFG_DATA[16*cfg_i +: 16];
    last     = is_rd ? (idx == IDX_W'(RD_OPS - 1)) : (idx == IDX_W'(WR_OPS - 1));
    op       = OP_STOP;
    wbyte    = 8'h00;
    rd_nack  = 1'b0;
    if (is_rd) begin
      case (idx)
        4'd0: op = OP_START;
        4'd1: begin op = OP_WRITE; wbyte = {DEV_ADDR, 1'b0}; end
        4'd2: begin op = OP_WRITE; wbyte = reg_addr[15:8]; end
        4'd3: begin op = OP_WRITE; wbyte = reg_addr[7:0]; end
        4'd4: op = OP_START;
        4'd5: begin op = OP_WRITE; wbyte = {DEV_ADDR, 1'b1}; end
        4'd6: op = OP_READ;
        4'd7: begin op = OP_READ; rd_nack = 1'b1; end
        default: op = OP_STOP;
      endcase
    end else begin
      case (idx)
        4'd0: op = OP_START;
        4'd1: begin op = OP_WRITE; wbyte = {DEV_ADDR, 1'b0}; end
        4'd2: begin op = OP_WRITE; wbyte = reg_addr[15:8]; end
        4'd3: begin op = OP_WRITE; wbyte = reg_addr[7:0]; end
        4'd4: begin op = OP_WRITE; wbyte = reg_data[15:8]; end
        4'd5: begin op = OP_WRITE; wbyte = reg_data[7:0]; end
        default: op = OP_STOP;
      endcase
    end
  end

endmodule

// File: rtl/i2c_cfg_status_cap.sv
module i2c_cfg_status_cap #(
  parameter int WORD_W = 16,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic              sel_final,
  input  logic              hi_half,
  input  logic [HALF_W-1:0] din,
  output logic [WORD_W-1:0] word_first,
  output logic [WORD_W-1:0] word_final
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word_first <= '0;
      word_final <= '0;
    end else if (wr_en) begin
      if (sel_final) begin
        if (hi_half) word_final[WORD_W-1:HALF_W] <= din;
        else         word_final[HALF_W-1:0]      <= din;
      end else begin
        if (hi_half) word_first[WORD_W-1:HALF_W] <= din;
        else         word_first[HALF_W-1:0]      <= din;
      end
    end
  end

endmodule

// File: rtl/i2c_cfg_sequencer.sv
module i2c_cfg_sequencer
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0]          DEV_ADDR   = 7'h2A,
  parameter logic [15:0]         STATUS_REG = 16'h0002,
  parameter int                  N_CFG      = 3,
  parameter logic [N_CFG*16-1:0] CFG_REGS   = {16'h0004, 16'h000A, 16'h0008},
  parameter logic [N_CFG*16-1:0] CFG_DATA   = {16'h0101, 16'h0002, 16'h0001}
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  output logic                             busy,
  output logic                             done,
  output logic                             error,
  output logic [$clog2(N_CFG+2)-1:0]       err_step,
  output logic [15:0]                      status_first,
  output logic [15:0]                      status_final,
  output logic                             cmd_req,
  output logic [1:0]                       cmd_op,
  output logic [7:0]                       cmd_wdata,
  output logic                             cmd_rd_nack,
  input  logic                             cmd_ack,
  input  logic                             rsp_nack,
  input  logic [7:0]                       rsp_rdata
);

  localparam int N_STEPS = N_CFG + 2;
  localparam int STEP_W  = $clog2(N_STEPS);

  seq_state_e        state;
  logic [STEP_W-1:0] step;
  logic [IDX_W-1:0]  idx;
  logic              abort;

  op_e               t_op;
  logic [7:0]        t_byte;
  logic              t_rd_nack;
  logic              t_last;
  logic [IDX_W-1:0]  t_stop_idx;

  i2c_cfg_cmd_table #(
    .DEV_ADDR   (DEV_ADDR),
    .STATUS_REG (STATUS_REG),
    .N_CFG      (N_CFG),
    .CFG_REGS   (CFG_REGS),
    .CFG_DATA   (CFG_DATA)
  ) u_table (
    .step    (step),
    .idx     (idx),
    .op      (t_op),
    .wbyte   (t_byte),
    .rd_nack (t_rd_nack),
    .last    (t_last)
  );

  // index of the closing STOP in the current transaction
  assign t_stop_idx = ((step == '0) || (step == STEP_W'(N_STEPS - 1))) ?
                      IDX_W'(RD_OPS - 1) : IDX_W'(WR_OPS - 1);

  logic accept;
  logic acked;
  assign accept = (state == S_IDLE) && start;
  assign acked  = (state == S_WAIT) && cmd_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      step        <= '0;
      idx         <= '0;
      abort       <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      error       <= 1'b0;
      err_step    <= '0;
      cmd_req     <= 1'b0;
      cmd_op      <= OP_START;
      cmd_wdata   <= '0;
      cmd_rd_nack <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            step     <= '0;
            idx      <= '0;
            abort    <= 1'b0;
            busy     <= 1'b1;
            done     <= 1'b0;
            error    <= 1'b0;
            err_step <= '0;
            state    <= S_LOAD;
          end
        end
        S_LOAD: begin
          cmd_req     <= 1'b1;
          cmd_op      <= t_op;
          cmd_wdata   <= t_byte;
          cmd_rd_nack <= t_rd_nack;
          state       <= S_WAIT;
        end
        S_WAIT: begin
          if (cmd_ack) begin
            cmd_req <= 1'b0;
            if (abort) begin
              state <= S_IDLE;
              busy  <= 1'b0;
              error <= 1'b1;
            end else if ((cmd_op == OP_WRITE) && rsp_nack) begin
              abort    <= 1'b1;
              err_step <= step;
              idx      <= t_stop_idx;
              state    <= S_LOAD;
            end else if (t_last) begin
              if (step == STEP_W'(N_STEPS - 1)) begin
                state <= S_IDLE;
                busy  <= 1'b0;
                done  <= 1'b1;
              end else begin
                step  <= step + 1'b1;
                idx   <= '0;
                state <= S_LOAD;
              end
            end else begin
              idx   <= idx + 1'b1;
              state <= S_LOAD;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  i2c_cfg_status_cap #(.WORD_W(16)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .clr        (accept),
    .wr_en      (acked && (cmd_op == OP_READ) && !abort),
    .sel_final  (step != '0),
    .hi_half    (!cmd_rd_nack),
    .din        (rsp_rdata),
    .word_first (status_first),
    .word_final (status_final)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_op) && $stable(cmd_wdata))); // R8
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && cmd_ack) |=> !cmd_req); // R8
  AST_NACK_STOP: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && cmd_ack && (cmd_op == OP_WRITE) && rsp_nack && !abort)
    |=> ##1 (cmd_req && (cmd_op == OP_STOP))); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && error)); // R9
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!done && !error)); // R9
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_req |-> busy); // R10
  AST_ERR_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
    error |-> (err_step <= STEP_W'(N_STEPS - 1))); // R6

endmodule

// File: tb/tb_i2c_cfg_sequencer.sv
module tb_i2c_cfg_sequencer;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, error;
  logic [2:0] err_step;
  logic [15:0] status_first, status_final;
  logic cmd_req, cmd_rd_nack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_wdata;
  logic cmd_ack = 1'b0;
  logic rsp_nack = 1'b0;
  logic [7:0] rsp_rdata = 8'h00;

  always #5 clk = ~clk;

  i2c_cfg_sequencer dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .error(error), .err_step(err_step), .status_first(status_first),
    .status_final(status_final), .cmd_req(cmd_req), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_rd_nack(cmd_rd_nack), .cmd_ack(cmd_ack),
    .rsp_nack(rsp_nack), .rsp_rdata(rsp_rdata)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected command stream, built from R2/R3/R4
  localparam int SEQ_N = 39;
  logic [1:0] e_op [SEQ_N];
  logic [7:0] e_b  [SEQ_N];
  logic       e_rn [SEQ_N];
  int e_n = 0;

  task automatic put(input logic [1:0] op, input logic [7:0] b, input logic rn);
    e_op[e_n] = op; e_b[e_n] = b; e_rn[e_n] = rn; e_n++;
  endtask

  task automatic put_status_read();
    put(2'd0, 8'h00, 1'b0); put(2'd1, 8'h54, 1'b0);
    put(2'd1, 8'h00, 1'b0); put(2'd1, 8'h02, 1'b0);
    put(2'd0, 8'h00, 1'b0); put(2'd1, 8'h55, 1'b0);
    put(2'd2, 8'h00, 1'b0); put(2'd2, 8'h00, 1'b1);
    put(2'd3, 8'h00, 1'b0);
  endtask

  task automatic put_write(input logic [15:0] r, input logic [15:0] d);
    put(2'd0, 8'h00, 1'b0); put(2'd1, 8'h54, 1'b0);
    put(2'd1, r[15:8], 1'b0); put(2'd1, r[7:0], 1'b0);
    put(2'd1, d[15:8], 1'b0); put(2'd1, d[7:0], 1'b0);
    put(2'd3, 8'h00, 1'b0);
  endtask

  // bit-engine model
  localparam int LAT = 3;
  logic [1:0] g_op [64];
  logic [7:0] g_b  [64];
  logic       g_rn [64];
  int n_ops = 0;
  int rd_cnt = 0;
  int lat = 0;
  int nack_at = 255;
  logic [7:0] rd_base = 8'h00;
  int hs_bad = 0;
  bit hold = 1'b0;
  logic [1:0] h_op;
  logic [7:0] h_w;

  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (hold && (!cmd_req || cmd_op != h_op || cmd_wdata != h_w)) hs_bad++;
        if (cmd_ack && cmd_req) hs_bad++;
      end
      cmd_ack  = 1'b0;
      rsp_nack = 1'b0;
      if (cmd_req && !rst) begin
        lat++;
        if (lat == LAT) begin
          lat = 0;
          if (n_ops < 64) begin
            g_op[n_ops] = cmd_op; g_b[n_ops] = cmd_wdata; g_rn[n_ops] = cmd_rd_nack;
          end
          rsp_nack = (n_ops == nack_at);
          if (cmd_op == 2'd2) begin
            rsp_rdata = rd_base + 8'(rd_cnt);
            rd_cnt++;
          end
          n_ops++;
          cmd_ack = 1'b1;
        end
      end else begin
        lat = 0;
      end
      hold = cmd_req && !cmd_ack && !rst;
      h_op = cmd_op;
      h_w  = cmd_wdata;
    end
  end

  task automatic prep(input int na, input logic [7:0] base);
    n_ops = 0; rd_cnt = 0; lat = 0; nack_at = na; rd_base = base;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  // {nack op index (FF none), read base, exp error, exp err_step}
  localparam logic [23:0] VEC [8] = '{
    {8'hFF, 8'h10, 4'd0, 4'd0},
    {8'h01, 8'h20, 4'd1, 4'd0},
    {8'h04, 8'h30, 4'd0, 4'd0},
    {8'h0C, 8'h40, 4'd1, 4'd1},
    {8'h19, 8'h50, 4'd1, 4'd3},
    {8'h1C, 8'h60, 4'd1, 4'd3},
    {8'h23, 8'h70, 4'd1, 4'd4},
    {8'h25, 8'h80, 4'd0, 4'd0}
  };

  task automatic check_stream(input bit is_err, input int na, input string req);
    int bad = 0;
    int exp_n = is_err ? na + 2 : SEQ_N;
    check(n_ops == exp_n, req, "command count", n_ops, exp_n);
    for (int i = 0; i < n_ops && i < SEQ_N; i++) begin
      logic [1:0] eo = (is_err && i == na + 1) ? 2'd3 : e_op[i];
      if (g_op[i] != eo) bad++;
      else if (eo == 2'd1 && g_b[i] != e_b[i]) bad++;
      else if (eo == 2'd2 && g_rn[i] != e_rn[i]) bad++;
    end
    check(bad == 0, req, "command stream mismatches", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    put_status_read();
    put_write(16'h0008, 16'h0001);
    put_write(16'h000A, 16'h0002);
    put_write(16'h0004, 16'h0101);
    put_status_read();

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(!busy && !done && !error && !cmd_req, "R10", "flags after reset",
          {busy, done, error, cmd_req}, 0);
    check(status_first == 0 && status_final == 0, "R10", "status after reset",
          {status_first, status_final}, 0);

    // R1 start latency
    prep(255, 8'hA0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !cmd_req, "R1", "busy one edge after start", {busy, cmd_req}, 2'b10);
    @(negedge clk);
    check(cmd_req && cmd_op == 2'd0, "R1", "first request two edges after start",
          {cmd_req, cmd_op}, 3'b100);
    // R1 start while busy is ignored
    repeat (40) @(negedge clk);
    pulse_start();
    wait_idle();
    check_stream(1'b0, 255, "R1");
    check(done && !error, "R4", "done after full run", {done, error}, 2'b10);
    check(status_first == 16'hA0A1, "R5", "first status", status_first, 16'hA0A1);
    check(status_final == 16'hA2A3, "R5", "final status", status_final, 16'hA2A3);
    repeat (5) @(negedge clk);
    check(done && !error, "R9", "done holds", {done, error}, 2'b10);

    // table walk
    for (int r = 0; r < 8; r++) begin
      int na = int'(VEC[r][23:16]);
      logic [7:0] base = VEC[r][15:8];
      bit ee = VEC[r][4];
      logic [2:0] es = VEC[r][2:0];
      string req = ee ? "R6" : (na == 255 ? "R3" : "R7");
      prep(na, base);
      pulse_start();
      check(!done && !error, "R9", "flags cleared on start", {done, error}, 0);
      wait_idle();
      check_stream(ee, na, req);
      check(done == !ee && error == ee, req, "done/error", {done, error}, {!ee, ee});
      if (ee) check(err_step == es, "R6", "err_step", err_step, es);
      if (!ee || es == 3'd4)
        check(status_first == {base, base + 8'd1}, "R5", "first status",
              status_first, {base, base + 8'd1});
      if (!ee)
        check(status_final == {base + 8'd2, base + 8'd3}, "R4", "final status",
              status_final, {base + 8'd2, base + 8'd3});
    end

    // R10 reset mid-run
    prep(255, 8'h00);
    pulse_start();
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !cmd_req && !done && !error, "R10", "reset mid-run",
          {busy, cmd_req, done, error}, 0);
    check(status_first == 0, "R10", "status cleared by reset", status_first, 0);

    check(hs_bad == 0, "R8", "handshake violations", hs_bad, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule